// File: doc/BRIEF.md
# Segment Display Refresh Controller

This block sits between a processor-side register write port and the frame sequencer of a segment display driver. Software fills a bank of sixteen display words, each write touching only the bits chosen by a mask. It then raises an update request. The request is only latched at that point. At the next start-of-frame strobe from the timing generator, the whole bank is copied into a shadow buffer that the sequencer scans out, and a completion flag is raised. Because of this, a frame never shows a half-written picture.

The controller also keeps the running status of the display. The running flag comes up as soon as the enable bit is turned on. After a disable it stays up until the frame in progress ends, which is marked by the next strobe. The block holds the start-of-frame and update-done flags, which software clears by writing ones, and it drives one interrupt line. It also holds sticky timeout error bits, which flag a request that never completes and a disable that never settles.

The write port is a plain strobe, not a valid/ready stream. A write to the display bank while an update is pending is dropped, not stalled, so the port has no back-pressure.

Top module: `seg_update_ctrl`

## Requirements
- R1: A write to address a (0 to 15) changes only the bits of word a whose mask bit is 1, to the data bit. After a transfer, word i appears at `disp_buf[i*32 +: 32]`.
- R2: After reset, every flag, every error bit, the interrupt and the whole display buffer are 0.
- R3: Address 16 is the control register: bit 0 enable, bit 1 start-of-frame interrupt enable, bit 2 update-done interrupt enable. The running flag `ens` is 1 in the cycle after a write that takes enable from 0 to 1.
- R4: After enable is cleared, `ens` stays 1 until a start-of-frame strobe arrives. It falls on that strobe, and that strobe does not set the start-of-frame flag.
- R5: Each start-of-frame strobe that arrives while enable is 1 sets `sof_flag`.
- R6: Writing bit 0 = 1 to address 17 sets `udr_flag`, and the display buffer holds its value. At the next start-of-frame strobe with enable 1, the buffer takes the whole bank, `udr_flag` clears and `udd_flag` sets, all on that same clock edge.
- R7: Writes to the display bank while `udr_flag` is 1 are ignored.
- R8: While enable is 0, start-of-frame strobes perform no transfer: `udd_flag` stays 0 and `udr_flag` stays 1.
- R9: Address 18 is the clear register. A 1 in bit 0 clears `sof_flag`, a 1 in bit 1 clears `udd_flag` and a 1 in bit 2 clears the error bits. Zero bits have no effect, and a flag set in the same cycle as its clear stays set.
- R10: `irq` is 1 exactly when (`sof_flag` and its enable) or (`udd_flag` and its enable) holds.
- R11: `err_code` bit 2 (value 4) sets once `udr_flag` has stayed 1 for TIMEOUT_CYC cycles. Bit 3 (value 8) sets once `ens` has stayed 1 with enable 0 for TIMEOUT_CYC cycles. Both bits stay set until cleared. Bits 0, 1 and 4 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address: 0-15 bank word, 16 control, 17 request, 18 clear |
| reg_wdata | input | WORD_W | Write data |
| reg_wmask | input | WORD_W | Bit mask for bank word writes |
| sof_strobe | input | 1 | One-cycle start-of-frame pulse from the timing generator |
| disp_buf | output | NWORDS*WORD_W | Shadow buffer scanned by the sequencer |
| ens | output | 1 | Display running flag |
| sof_flag | output | 1 | Start-of-frame flag |
| udr_flag | output | 1 | Update request pending |
| udd_flag | output | 1 | Update done flag |
| err_code | output | 5 | Sticky timeout error bits |
| irq | output | 1 | Interrupt line |

## Verification
The bank is internal, so a wrong word or a leaked masked bit stays hidden until the next transfer. It then shows up in `disp_buf` on the edge of the strobe that completes the request. A request flag stuck high shows one strobe later: the buffer does not move, `udd_flag` stays low and writes are still dropped. A wrong running-flag state shows either as `ens` dropping before the terminating strobe or as a spurious start-of-frame flag on that strobe. A broken timeout counter only shows TIMEOUT_CYC cycles later, in `err_code`.

// File: rtl/seg_pkg.sv
package seg_pkg;
  // control register layout, enable in bit 0
  typedef struct packed {
    logic udd_ie;
    logic sof_ie;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = 3;
  localparam int unsigned ERR_W = 5;
  localparam int unsigned ERR_BIT_UDD = 2;
  localparam int unsigned ERR_BIT_ENS = 3;
  localparam int unsigned CLR_SOF = 0;
  localparam int unsigned CLR_UDD = 1;
  localparam int unsigned CLR_ERR = 2;
endpackage

// File: rtl/seg_timeout.sv
module seg_timeout #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!cond)                  cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CNT_W'(LIMIT));

  // R11
  tmo_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> !expired);
endmodule

// File: rtl/seg_ram_bank.sv
module seg_ram_bank #(
  parameter int unsigned NWORDS = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = $clog2(NWORDS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDX_W-1:0]               idx,
  input  logic [WORD_W-1:0]              mask,
  input  logic [WORD_W-1:0]              wdata,
  input  logic                           lock,
  input  logic                           xfer,
  output logic [NWORDS-1:0][WORD_W-1:0]  buf_q
);
  logic [NWORDS-1:0][WORD_W-1:0] ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= '0;
    end else if (we && !lock) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (idx == IDX_W'(i))
          ram_q[i] <= (ram_q[i] & ~mask) | (wdata & mask);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_q <= '0;
    else if (xfer) buf_q <= ram_q;
  end

  // R7
  ram_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> $stable(ram_q));
  // R6
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(buf_q));
endmodule

// File: rtl/seg_flag_unit.sv
module seg_flag_unit
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  ctrl_t            ctrl_wdata,
  input  logic             req_we,
  input  logic             req_bit,
  input  logic             clr_we,
  input  logic [2:0]       clr_bits,
  input  logic             sof_strobe,
  input  logic             udd_tmo,
  input  logic             ens_tmo,
  output ctrl_t            ctrl_q,
  output logic             ens,
  output logic             sof_flag,
  output logic             udr,
  output logic             udd,
  output logic             xfer,
  output logic [ERR_W-1:0] err_code
);
  logic ctrl_en;
  logic frame_go;
  logic err_udd_q, err_ens_q;
  logic clr_sof, clr_udd, clr_err;

  assign ctrl_en  = ctrl_q.en;
  assign frame_go = sof_strobe && ctrl_en;
  assign xfer     = frame_go && udr;
  assign clr_sof  = clr_we && clr_bits[CLR_SOF];
  assign clr_udd  = clr_we && clr_bits[CLR_UDD];
  assign clr_err  = clr_we && clr_bits[CLR_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  // running flag: up at once on enable, down only at the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      ens <= 1'b0;
    else if (ctrl_we && ctrl_wdata.en && !ctrl_en)   ens <= 1'b1;
    else if (sof_strobe && !ctrl_en)                 ens <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_flag  <= 1'b0;
      udr       <= 1'b0;
      udd       <= 1'b0;
      err_udd_q <= 1'b0;
      err_ens_q <= 1'b0;
    end else begin
      if (frame_go)      sof_flag <= 1'b1;
      else if (clr_sof)  sof_flag <= 1'b0;

      if (req_we && req_bit) udr <= 1'b1;
      else if (xfer)         udr <= 1'b0;

      if (xfer)          udd <= 1'b1;
      else if (clr_udd)  udd <= 1'b0;

      if (udd_tmo)       err_udd_q <= 1'b1;
      else if (clr_err)  err_udd_q <= 1'b0;

      if (ens_tmo)       err_ens_q <= 1'b1;
      else if (clr_err)  err_ens_q <= 1'b0;
    end
  end

  always_comb begin
    err_code              = '0;
    err_code[ERR_BIT_UDD] = err_udd_q;
    err_code[ERR_BIT_ENS] = err_ens_q;
  end

  // R3
  ens_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> ens);
  // R4
  ens_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ens) |-> ($past(sof_strobe) && !$past(ctrl_en)));
  // R8
  udd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udd) |-> $past(ctrl_en));
  // R6
  udr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(udr) |-> ($past(sof_strobe) && udd));
endmodule

// File: rtl/seg_update_ctrl.sv
module seg_update_ctrl
  import seg_pkg::*;
#(
  parameter int unsigned NWORDS      = 16,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned ADDR_W      = $clog2(NWORDS + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  input  logic [WORD_W-1:0]        reg_wmask,
  input  logic                     sof_strobe,
  output logic [NWORDS*WORD_W-1:0] disp_buf,
  output logic                     ens,
  output logic                     sof_flag,
  output logic                     udr_flag,
  output logic                     udd_flag,
  output logic [ERR_W-1:0]         err_code,
  output logic                     irq
);
  localparam int unsigned IDX_W = $clog2(NWORDS);
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(NWORDS);
  localparam logic [ADDR_W-1:0] ADR_REQ  = ADDR_W'(NWORDS + 1);
  localparam logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(NWORDS + 2);
  localparam int unsigned NTMO = 2;

  logic ram_we, ctrl_we, req_we, clr_we, xfer;
  ctrl_t ctrl_q;
  logic [NTMO-1:0] tmo_cond, tmo_hit;
  logic [NWORDS-1:0][WORD_W-1:0] buf_q;

  assign ram_we  = reg_we && (reg_addr < ADR_CTRL);
  assign ctrl_we = reg_we && (reg_addr == ADR_CTRL);
  assign req_we  = reg_we && (reg_addr == ADR_REQ);
  assign clr_we  = reg_we && (reg_addr == ADR_CLR);

  seg_ram_bank #(.NWORDS(NWORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .idx   (reg_addr[IDX_W-1:0]),
    .mask  (reg_wmask),
    .wdata (reg_wdata),
    .lock  (udr_flag),
    .xfer  (xfer),
    .buf_q (buf_q)
  );

  seg_flag_unit u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .req_we     (req_we),
    .req_bit    (reg_wdata[0]),
    .clr_we     (clr_we),
    .clr_bits   (reg_wdata[2:0]),
    .sof_strobe (sof_strobe),
    .udd_tmo    (tmo_hit[0]),
    .ens_tmo    (tmo_hit[1]),
    .ctrl_q     (ctrl_q),
    .ens        (ens),
    .sof_flag   (sof_flag),
    .udr        (udr_flag),
    .udd        (udd_flag),
    .xfer       (xfer),
    .err_code   (err_code)
  );

  // watcher 0: request never served; watcher 1: disable never settles
  assign tmo_cond[0] = udr_flag;
  assign tmo_cond[1] = ens && !ctrl_q.en;

  for (genvar g = 0; g < NTMO; g++) begin : g_tmo
    seg_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (tmo_cond[g]),
      .expired (tmo_hit[g])
    );
  end

  assign disp_buf = buf_q;
  assign irq = (sof_flag && ctrl_q.sof_ie) || (udd_flag && ctrl_q.udd_ie);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sof_flag || udd_flag));
  // R11
  err_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_code[ERR_BIT_UDD]) |-> $past(udr_flag));
endmodule

// File: tb/seg_update_ctrl_tb.sv
module seg_update_ctrl_tb;
  localparam int NW = 16;
  localparam int WW = 32;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [WW-1:0] reg_wdata = '0;
  logic [WW-1:0] reg_wmask = '0;
  logic sof_strobe = 1'b0;
  logic [NW*WW-1:0] disp_buf;
  logic ens, sof_flag, udr_flag, udd_flag, irq;
  logic [4:0] err_code;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] ram_m [NW];

  always #10 clk = ~clk;

  seg_update_ctrl #(.NWORDS(NW), .WORD_W(WW), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .sof_strobe(sof_strobe),
    .disp_buf(disp_buf), .ens(ens), .sof_flag(sof_flag), .udr_flag(udr_flag),
    .udd_flag(udd_flag), .err_code(err_code), .irq(irq)
  );

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_buf(input string tag);
    for (int i = 0; i < NW; i++) check(tag, disp_buf[i*WW +: WW], ram_m[i]);
  endtask

  task automatic wr(input logic [4:0] a, input logic [WW-1:0] d, input logic [WW-1:0] m);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; reg_wmask = '0;
  endtask

  task automatic pulse_sof(input logic [WW-1:0] clr);
    @(negedge clk);
    sof_strobe = 1'b1;
    if (clr != '0) begin reg_we = 1'b1; reg_addr = 5'd18; reg_wdata = clr; end
    @(negedge clk);
    sof_strobe = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    check("R2 ens", ens, 0);
    check("R2 sof", sof_flag, 0);
    check("R2 udr", udr_flag, 0);
    check("R2 udd", udd_flag, 0);
    check("R2 err", err_code, 0);
    check("R2 irq", irq, 0);
    check("R2 buf", disp_buf[WW-1:0] | disp_buf[NW*WW-1 -: WW], 0);
  endtask

  task automatic t_enable_and_frame();
    wr(5'd16, 32'h1, '0);
    check("R3 ens after enable", ens, 1);
    check("R5 sof before strobe", sof_flag, 0);
    pulse_sof('0);
    check("R5 sof after strobe", sof_flag, 1);
    check("R6 no done without request", udd_flag, 0);
    wr(5'd18, 32'h2, '0);
    check("R9 zero bit keeps sof", sof_flag, 1);
    wr(5'd18, 32'h1, '0);
    check("R9 sof cleared", sof_flag, 0);
  endtask

  task automatic t_masked_update();
    wr(5'd3, 32'hAAAA_5555, 32'hFFFF_FFFF);
    wr(5'd3, 32'h0000_FFFF, 32'h0000_00FF);
    wr(5'd15, 32'h1234_5678, 32'hFFFF_FFFF);
    ram_m[3] = 32'hAAAA_55FF;
    ram_m[15] = 32'h1234_5678;
    wr(5'd17, 32'h1, '0);
    check("R6 request latched", udr_flag, 1);
    check("R6 buffer waits for frame", disp_buf[3*WW +: WW], 0);
    pulse_sof('0);
    check("R6 request served", udr_flag, 0);
    check("R6 done set", udd_flag, 1);
    check_buf("R1 masked words in buffer");
  endtask

  task automatic t_lock();
    wr(5'd17, 32'h1, '0);
    wr(5'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    pulse_sof(32'h3);
    check("R9 set beats clear", sof_flag, 1);
    check("R7 locked write dropped", disp_buf[WW-1:0], 0);
    wr(5'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    ram_m[0] = 32'hDEAD_BEEF;
    wr(5'd17, 32'h1, '0);
    pulse_sof('0);
    check_buf("R7 write accepted after done");
    wr(5'd18, 32'h2, '0);
    check("R9 udd cleared", udd_flag, 0);
    check("R9 sof kept by bit0=0", sof_flag, 1);
  endtask

  task automatic t_irq();
    wr(5'd18, 32'h3, '0);
    wr(5'd16, 32'h3, '0);
    check("R10 irq idle", irq, 0);
    pulse_sof('0);
    check("R10 irq from sof", irq, 1);
    wr(5'd18, 32'h1, '0);
    check("R10 irq after clear", irq, 0);
    wr(5'd16, 32'h5, '0);
    pulse_sof('0);
    check("R10 sof masked", irq, 0);
    wr(5'd17, 32'h1, '0);
    pulse_sof('0);
    check("R10 irq from udd", irq, 1);
    wr(5'd18, 32'h3, '0);
    check("R10 irq dropped", irq, 0);
  endtask

  task automatic t_disable();
    wr(5'd16, 32'h0, '0);
    check("R4 ens held after disable", ens, 1);
    wr(5'd17, 32'h1, '0);
    wr(5'd1, 32'h5A5A_5A5A, 32'hFFFF_FFFF);
    pulse_sof('0);
    check("R4 ens falls at frame end", ens, 0);
    check("R4 no sof on last strobe", sof_flag, 0);
    check("R8 no done while off", udd_flag, 0);
    pulse_sof('0);
    check("R8 request still pending", udr_flag, 1);
    check("R8 no done second strobe", udd_flag, 0);
    check_buf("R8 buffer unchanged");
  endtask

  task automatic t_timeouts();
    check("R11 no error yet", err_code, 0);
    repeat (TMO + 16) @(negedge clk);
    check("R11 request timeout", err_code, 5'd4);
    wr(5'd16, 32'h1, '0);
    pulse_sof('0);
    check_buf("R7 pending write dropped");
    check("R11 error sticky", err_code, 5'd4);
    wr(5'd18, 32'h4, '0);
    check("R11 error cleared", err_code, 0);
    wr(5'd16, 32'h0, '0);
    repeat (TMO + 16) @(negedge clk);
    check("R4 ens still held", ens, 1);
    check("R11 disable timeout", err_code, 5'd8);
    pulse_sof('0);
    check("R4 ens drops", ens, 0);
    wr(5'd18, 32'h4, '0);
    check("R11 error cleared again", err_code, 0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) ram_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_and_frame();
    t_masked_update();
    t_lock();
    t_irq();
    t_disable();
    t_timeouts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule